// File: doc/BRIEF.md
# Alarm Page Write Tracker with Nonvolatile Commit Decision

This block sits behind a byte-wide serial write port and in front of a 16-byte alarm register page. The page holds two alarms of eight bytes each: alarm 0 at 0x00 to 0x07 and alarm 1 at 0x08 to 0x0F. A write transaction opens with a start strobe that carries the first address. Each data strobe that follows writes one byte at the current address, which then advances by one and wraps from 0x0F to 0x00 inside the page. A stop strobe closes the transaction. Every accepted byte goes straight out as a register write, so the volatile registers always follow the port.

At the stop the block decides whether the transaction may also be made nonvolatile. Only the address of the last byte written matters. If that address sits in the lower five bytes of either alarm (0x00 to 0x04 or 0x08 to 0x0C), the block raises a one-cycle commit request. The request carries a 16-bit mask with one bit for every page byte written since the start. A transaction that ends at any of the upper three bytes of an alarm (0x05 to 0x07 or 0x0D to 0x0F) updates the registers but requests no commit. To make such bytes durable, software writes on past them into a committing address, for example with a full 16-byte wrap from 0x01 round to 0x00.

Top module: `alarm_commit_ctrl`

## Requirements
- R1: After synchronous reset, wr_en and commit_pulse are low, commit_mask is zero and no transaction is open.
- R2: A byte_valid strobe inside an open transaction causes wr_en to be high for exactly one cycle on the next cycle. wr_addr holds the current address and wr_data holds the strobe's byte. The first byte of a transaction goes to start_addr.
- R3: Each accepted byte advances the write address by one. After 0x0F the next address is 0x00.
- R4: byte_valid and stop_valid strobes that arrive while no transaction is open are ignored: they produce no wr_en and no commit_pulse.
- R5: A stop inside an open transaction whose last written address is 0x00–0x04 or 0x08–0x0C (address bits [2:0] in 0..4) raises commit_pulse for one cycle on the next cycle.
- R6: A stop whose last written address is 0x05–0x07 or 0x0D–0x0F raises no commit_pulse. The bytes of that transaction are still written through wr_en.
- R7: During commit_pulse, bit i of commit_mask is 1 exactly when address i was written since the transaction's start. Whenever commit_pulse is low, commit_mask is zero.
- R8: A stop in a transaction that wrote no byte raises no commit_pulse.
- R9: A start inside an open transaction drops that transaction without a commit, clears the mask and opens a new transaction at the new address.
- R10: A transaction longer than 16 bytes keeps wrapping and overwriting. The mask saturates at all ones, and only the final address decides the commit.
- R11: When strobes coincide, start wins over byte, and byte wins over stop. The losing strobes in that cycle are ignored.
- R12: A 16-byte write from 0x01 ending at 0x00, or from 0x09 ending at 0x08, commits with mask 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Opens a transaction at start_addr |
| start_addr | input | 4 | First page address of the transaction |
| byte_valid | input | 1 | One data byte is present on byte_data |
| byte_data | input | 8 | Data byte to write |
| stop_valid | input | 1 | Closes the open transaction |
| wr_en | output | 1 | Register write strobe, one cycle per accepted byte |
| wr_addr | output | 4 | Page address of the register write |
| wr_data | output | 8 | Data of the register write |
| commit_pulse | output | 1 | One-cycle nonvolatile commit request |
| commit_mask | output | 16 | Bytes written in the committing transaction |

## Verification
The bench aims at the addresses where the commit decision flips. These are the last committing address of each alarm (0x04, 0x0C), the first refused one (0x05, 0x0D), the day byte 0x06 and the top bytes 0x07 and 0x0F. A design that decoded the wrong range would commit on one of these or refuse one. The bench also runs writes that wrap past 0x0F and writes longer than the page. A design that stopped at the page end or kept the first address would write to the wrong place or judge the wrong byte. Repeated starts, empty transactions, strobes outside a transaction and coinciding strobes are aimed at a mask that is never cleared, at spurious commits, and at the wrong strobe winning.

// File: rtl/alarm_commit_pkg.sv
package alarm_commit_pkg;

    localparam int PAGE_BYTES_D  = 16;
    localparam int ALARM_BYTES_D = 8;
    localparam int COMMIT_SPAN_D = 5;
    localparam int DATA_W_D      = 8;

    // Decoded strobe of one cycle, after priority resolution
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_BYTE  = 2'd2,
        EV_STOP  = 2'd3
    } strobe_ev_e;

    // Transaction status flags
    typedef struct packed {
        logic open;
        logic wrote;
    } txn_flags_t;

    // True when a transaction ending at addr may request a commit
    function automatic logic commit_ok(int addr, int alarm_bytes, int span);
        return (addr % alarm_bytes) < span;
    endfunction

    // Next address inside a page of page_bytes entries
    function automatic int page_next(int addr, int page_bytes);
        return (addr == page_bytes - 1) ? 0 : addr + 1;
    endfunction

endpackage

// File: rtl/acm_strobe_decode.sv
module acm_strobe_decode
    import alarm_commit_pkg::*;
(
    input  logic       start_valid,
    input  logic       byte_valid,
    input  logic       stop_valid,
    output strobe_ev_e ev
);

    always_comb begin
        if (start_valid) begin
            ev = EV_START;
        end else if (byte_valid) begin
            ev = EV_BYTE;
        end else if (stop_valid) begin
            ev = EV_STOP;
        end else begin
            ev = EV_NONE;
        end
    end

endmodule

// File: rtl/acm_addr_track.sv
module acm_addr_track
    import alarm_commit_pkg::*;
#(
    parameter int PAGE_BYTES = PAGE_BYTES_D,
    parameter int ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_e        ev,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] last_addr,
    output txn_flags_t        flags
);

    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        next_addr = ADDR_W'(page_next(int'(cur_addr), PAGE_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            last_addr <= '0;
            flags     <= '0;
        end else begin
            case (ev)
                EV_START: begin
                    cur_addr    <= start_addr;
                    flags.open  <= 1'b1;
                    flags.wrote <= 1'b0;
                end
                EV_BYTE: begin
                    if (flags.open) begin
                        last_addr   <= cur_addr;
                        cur_addr    <= next_addr;
                        flags.wrote <= 1'b1;
                    end
                end
                EV_STOP: begin
                    flags.open <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/acm_mask_accum.sv
module acm_mask_accum
    import alarm_commit_pkg::*;
#(
    parameter int PAGE_BYTES = PAGE_BYTES_D,
    parameter int ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  strobe_ev_e            ev,
    input  logic                  open,
    input  logic [ADDR_W-1:0]     cur_addr,
    output logic [PAGE_BYTES-1:0] mask
);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[i] <= 1'b0;
            end else if (ev == EV_START) begin
                mask[i] <= 1'b0;
            end else if (ev == EV_BYTE && open && cur_addr == ADDR_W'(i)) begin
                mask[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/alarm_commit_ctrl.sv
module alarm_commit_ctrl
    import alarm_commit_pkg::*;
#(
    parameter int PAGE_BYTES  = PAGE_BYTES_D,
    parameter int ALARM_BYTES = ALARM_BYTES_D,
    parameter int COMMIT_SPAN = COMMIT_SPAN_D,
    parameter int DATA_W      = DATA_W_D,
    parameter int ADDR_W      = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_valid,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic                  byte_valid,
    input  logic [DATA_W-1:0]     byte_data,
    input  logic                  stop_valid,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  commit_pulse,
    output logic [PAGE_BYTES-1:0] commit_mask
);

    strobe_ev_e            ev;
    txn_flags_t            flags;
    logic [ADDR_W-1:0]     cur_addr;
    logic [ADDR_W-1:0]     last_addr;
    logic [PAGE_BYTES-1:0] mask;
    logic                  byte_take;
    logic                  commit_now;

    acm_strobe_decode u_dec (
        .start_valid (start_valid),
        .byte_valid  (byte_valid),
        .stop_valid  (stop_valid),
        .ev          (ev)
    );

    acm_addr_track #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .start_addr (start_addr),
        .cur_addr   (cur_addr),
        .last_addr  (last_addr),
        .flags      (flags)
    );

    acm_mask_accum #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_mask (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .open     (flags.open),
        .cur_addr (cur_addr),
        .mask     (mask)
    );

    always_comb begin
        byte_take  = (ev == EV_BYTE) && flags.open;
        commit_now = (ev == EV_STOP) && flags.open && flags.wrote &&
                     commit_ok(int'(last_addr), ALARM_BYTES, COMMIT_SPAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en        <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            commit_pulse <= 1'b0;
            commit_mask  <= '0;
        end else begin
            wr_en        <= byte_take;
            commit_pulse <= commit_now;
            commit_mask  <= commit_now ? mask : '0;
            if (byte_take) begin
                wr_addr <= cur_addr;
                wr_data <= byte_data;
            end
        end
    end

endmodule

// File: rtl/acm_checker.sv
module acm_checker #(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_valid,
    input logic                  byte_valid,
    input logic                  stop_valid,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic                  commit_pulse,
    input logic [PAGE_BYTES-1:0] commit_mask
);

    logic [ADDR_W-1:0] succ_addr;

    always_comb begin
        succ_addr = (int'(wr_addr) == PAGE_BYTES - 1) ? '0 : wr_addr + 1'b1;
    end

    // R2
    wr_from_byte_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(byte_valid) && !$past(start_valid)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(succ_addr)));

    // R5
    commit_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> ($past(stop_valid) && !$past(start_valid) && !$past(byte_valid)));

    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !commit_pulse);

    // R7
    mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_pulse |-> (commit_mask == '0));

    // R7
    mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> (commit_mask != '0));

endmodule

bind alarm_commit_ctrl acm_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_valid  (start_valid),
    .byte_valid   (byte_valid),
    .stop_valid   (stop_valid),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .commit_pulse (commit_pulse),
    .commit_mask  (commit_mask)
);

// File: tb/test_alarm_commit_ctrl.sv
`timescale 1ns/1ps
module test_alarm_commit_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic [3:0]  start_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_valid = 1'b0;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        commit_pulse;
    logic [15:0] commit_mask;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alarm_commit_ctrl i_alarm_commit_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_valid  (start_valid),
        .start_addr   (start_addr),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .stop_valid   (stop_valid),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .commit_pulse (commit_pulse),
        .commit_mask  (commit_mask)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          m_open, m_any;
    int          m_ptr, m_last;
    bit [15:0]   m_mask;
    bit          e_wr, e_cp;
    int          e_addr, e_data;
    bit [15:0]   e_cm;

    function automatic bit commits_at(int a);
        return a inside {0, 1, 2, 3, 4, 8, 9, 10, 11, 12};
    endfunction

    always @(posedge clk) begin
        e_wr = 0;
        e_cp = 0;
        e_cm = '0;
        if (rst) begin
            m_open = 0; m_any = 0; m_ptr = 0; m_last = 0; m_mask = '0;
        end else if (start_valid) begin
            m_open = 1; m_any = 0; m_ptr = start_addr; m_mask = '0;
        end else if (byte_valid) begin
            if (m_open) begin
                e_wr = 1; e_addr = m_ptr; e_data = byte_data;
                m_mask[m_ptr] = 1'b1; m_last = m_ptr; m_any = 1;
                m_ptr = (m_ptr + 1) % 16;
            end
        end else if (stop_valid) begin
            if (m_open) begin
                m_open = 0;
                if (m_any && commits_at(m_last)) begin
                    e_cp = 1; e_cm = m_mask;
                end
            end
        end
    end

    // Per-cycle comparison and scenario monitor
    int        n_wr, n_commit;
    int        seen_mask;

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(wr_en == e_wr, "R2 wr_en model", wr_en, e_wr);
            if (e_wr) begin
                chk(wr_addr == 4'(e_addr), "R3 wr_addr model", wr_addr, e_addr);
                chk(wr_data == 8'(e_data), "R2 wr_data model", wr_data, e_data);
            end
            chk(commit_pulse == e_cp, "R5 commit_pulse model", commit_pulse, e_cp);
            chk(commit_mask == e_cm, "R7 commit_mask model", commit_mask, e_cm);
            if (wr_en) n_wr++;
            if (commit_pulse) begin
                n_commit++;
                seen_mask = commit_mask;
            end
        end
    end

    task automatic strobe(input bit s, input int a, input bit b, input int d, input bit p);
        @(negedge clk);
        start_valid = s; start_addr = 4'(a);
        byte_valid = b; byte_data = 8'(d);
        stop_valid = p;
        @(negedge clk);
        start_valid = 0; byte_valid = 0; stop_valid = 0;
    endtask

    task automatic txn(input int a, input int nbytes);
        strobe(1, a, 0, 0, 0);
        for (int k = 0; k < nbytes; k++) strobe(0, 0, 1, 8'hA0 + k, 0);
        strobe(0, 0, 0, 0, 1);
    endtask

    task automatic settle_and_clear();
        repeat (3) @(negedge clk);
    endtask

    task automatic reset_counts();
        n_wr = 0; n_commit = 0; seen_mask = 0;
    endtask

    task automatic expect_commit(input string tag, input int nc, input int msk, input int nw);
        settle_and_clear();
        chk(n_commit == nc, {tag, " commit count"}, n_commit, nc);
        if (nc > 0) chk(seen_mask == msk, {tag, " mask"}, seen_mask, msk);
        chk(n_wr == nw, {tag, " write count"}, n_wr, nw);
        reset_counts();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset_counts();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(wr_en == 0, "R1 wr_en after reset", wr_en, 0);
        chk(commit_pulse == 0, "R1 commit_pulse after reset", commit_pulse, 0);
        chk(commit_mask == 0, "R1 commit_mask after reset", commit_mask, 0);
        reset_counts();

        // R4 strobes with no open transaction
        strobe(0, 0, 1, 8'h55, 0);
        strobe(0, 0, 0, 0, 1);
        expect_commit("R4 idle strobes", 0, 0, 0);

        // R5 single byte at 0x02
        txn(2, 1);
        expect_commit("R5 single 0x02", 1, 16'h0004, 1);
        // R5 boundary 0x04 and 0x0C commit
        txn(4, 1);
        expect_commit("R5 single 0x04", 1, 16'h0010, 1);
        txn(12, 1);
        expect_commit("R5 single 0x0C", 1, 16'h1000, 1);
        // R6 boundaries that refuse
        txn(5, 1);
        expect_commit("R6 single 0x05", 0, 0, 1);
        txn(6, 1);
        expect_commit("R6 day byte 0x06", 0, 0, 1);
        txn(13, 1);
        expect_commit("R6 single 0x0D", 0, 0, 1);
        txn(12, 4);
        expect_commit("R6 ends at 0x0F", 0, 0, 4);
        // R5 day byte covered by overlap 0x06..0x08
        txn(6, 3);
        expect_commit("R5 overlap 0x06-0x08", 1, 16'h01C0, 3);
        // R3 wrap 0x0E,0x0F,0x00
        txn(14, 3);
        expect_commit("R3 wrap", 1, 16'hC001, 3);
        // R12 full pages
        txn(1, 16);
        expect_commit("R12 page from 0x01", 1, 16'hFFFF, 16);
        txn(9, 16);
        expect_commit("R12 page from 0x09", 1, 16'hFFFF, 16);
        // R8 empty transaction
        txn(3, 0);
        expect_commit("R8 empty", 0, 0, 0);
        // R9 repeated start
        strobe(1, 3, 0, 0, 0);
        strobe(0, 0, 1, 8'h11, 0);
        txn(8, 1);
        expect_commit("R9 restart mask", 1, 16'h0100, 2);
        strobe(1, 2, 0, 0, 0);
        strobe(0, 0, 1, 8'h22, 0);
        txn(5, 2);
        expect_commit("R9 restart refuse", 0, 0, 3);
        // R10 longer than a page
        txn(0, 18);
        expect_commit("R10 18 bytes", 1, 16'hFFFF, 18);
        txn(0, 22);
        expect_commit("R10 22 bytes", 0, 0, 22);
        // R11 start beats byte
        strobe(1, 10, 1, 8'h77, 0);
        strobe(0, 0, 0, 0, 1);
        expect_commit("R11 start over byte", 0, 0, 0);
        // R11 byte beats stop
        strobe(1, 2, 0, 0, 0);
        strobe(0, 0, 1, 8'h33, 1);
        settle_and_clear();
        chk(n_commit == 0, "R11 byte over stop", n_commit, 0);
        strobe(0, 0, 0, 0, 1);
        expect_commit("R11 later stop", 1, 16'h0004, 1);
        // R4 bytes after stop
        strobe(0, 0, 1, 8'h99, 0);
        expect_commit("R4 after stop", 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule